// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Controller

This block turns single read and write requests from an internal requester into cycles on an external parallel bus. The bus serves asynchronous SRAM, ROM, FRAM and NOR-style parts. The upper request address bits choose one of four banks, and each bank has its own active-low chip select. All the other lines are shared by every bank: address, data, output enable, write enable and the address-valid strobe.

Each bank has a read timing set and a separate write timing set. A set holds the strobe delay, the wait states and the turnaround gap, each from 0 to 15 cycles. Each bank also has two option bits. One picks an 8-bit or a 16-bit data width. The other selects a multiplexed bus, which puts a one-cycle address phase on the data lines ahead of the data phase.

The requester holds `req_valid` until `busy` shows the controller is idle. It then waits for the one-cycle `done` pulse. For reads, `rd_data` is valid in the same cycle as `done`.

Top module: `amc_top`

## Requirements
- R1: Request address bits [27:26] select the bank. While a cycle is active, only `mem_cs_n[bank]` is low, and it stays low without a break from the first cycle of the transaction to the last strobe or hold cycle.
- R2: `mem_addr` is driven for the whole cycle. A bank with 16-bit width gets the halfword address `{1'b0, req_addr[25:1]}`. A bank with 8-bit width gets the byte address `req_addr[25:0]`.
- R3: On a bank with multiplexed mode set, the first cycle is an address phase. In that cycle `mem_adv_n` is low, `mem_dq_oe` is high, `mem_dq_out` equals `mem_addr[15:0]`, and both strobes are high. On a bank without multiplexed mode, `mem_adv_n` never goes low.
- R4: The timing set word for bank b sits at bits [12b+11 : 12b]. Its fields are wait states [3:0], strobe delay [7:4] and turnaround [11:8]. The strobe (OE for a read, WE for a write) goes low after exactly M+D cycles with the chip select low, where M is 1 in multiplexed mode and 0 otherwise, and D is the strobe delay.
- R5: The strobe stays low for exactly W+1 cycles, where W is the wait-state count.
- R6: During a write, `mem_dq_out` carries the write data while WE is low, zero-extended from bits [7:0] for an 8-bit bank. WE rises one cycle before the data and the chip select are released, and OE and WE are never low at the same time.
- R7: A read samples `mem_dq_in` in the last strobe cycle, and `mem_dq_oe` stays low while OE is low. An 8-bit bank returns `{8'h00, mem_dq_in[7:0]}`.
- R8: After the chip select rises there are exactly T cycles with `busy` high and all selects high, where T is the turnaround. `done` is asserted in the following cycle.
- R9: Reads use the `cfg_rd_tim` set and writes use the `cfg_wr_tim` set of the addressed bank.
- R10: `done` lasts exactly one cycle, and `busy` is low in that cycle. `busy` is high from the cycle after acceptance until then. A request presented while `busy` is high is held off and does not disturb the cycle in progress.
- R11: After reset, every select and strobe is high, `mem_dq_oe`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Byte address; bits [27:26] select the bank |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Cycle or turnaround in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| cfg_rd_tim | input | 48 | Read timing set, 12 bits per bank |
| cfg_wr_tim | input | 48 | Write timing set, 12 bits per bank |
| cfg_wide | input | 4 | Per bank: 1 = 16-bit data, 0 = 8-bit |
| cfg_mux | input | 4 | Per bank: 1 = multiplexed address/data |
| mem_cs_n | output | 4 | Per-bank chip selects, active low |
| mem_addr | output | 26 | Shared external address |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 16 | Data/address driven onto the bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned by the device |

## Verification
The bench runs every bank in both directions. The timing values include the extremes: zero delay, zero wait and zero turnaround, and fifteen of each. A counter that loads one less than the programmed value, or skips a state when a field is zero, shows up as a wrong count of pre-strobe, strobe or turnaround cycles. If the read and write sets are swapped, or the bank index is taken from the wrong bits, the bench sees a wrong chip select or wrong timings. Requests are issued back to back, with the next one already waiting while `busy` is high. A controller that accepts during a cycle therefore stretches or splits the chip select. Dropping the write hold cycle, sampling read data off by one cycle, or mishandling the halfword shift or the zero-extension for 8-bit banks gives wrong data or a wrong address at completion.

// File: rtl/amc_pkg.sv
package amc_pkg;
  localparam int TF_W = 4;
  localparam int TIM_W = 3 * TF_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_TURN
  } amc_state_e;

  typedef struct packed {
    logic [TF_W-1:0] turn;
    logic [TF_W-1:0] dly;
    logic [TF_W-1:0] wst;
  } amc_tim_t;
endpackage

// File: rtl/amc_bank_sel.sv
module amc_bank_sel
  import amc_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 28
) (
  input  logic [AW-1:0]          addr,
  input  logic                   is_wr,
  input  logic [NBANK*TIM_W-1:0] rd_tim_all,
  input  logic [NBANK*TIM_W-1:0] wr_tim_all,
  input  logic [NBANK-1:0]       wide_all,
  input  logic [NBANK-1:0]       mux_all,
  output logic [NBANK-1:0]       sel_oh,
  output amc_tim_t               tim,
  output logic                   wide,
  output logic                   mux
);
  localparam int BW  = $clog2(NBANK);
  localparam int LSB = AW - BW;

  logic [BW-1:0]    idx;
  logic [TIM_W-1:0] rd_set;
  logic [TIM_W-1:0] wr_set;

  assign idx = addr[LSB +: BW];

  genvar g;
  generate
    for (g = 0; g < NBANK; g++) begin : g_bank
      assign sel_oh[g] = (idx == BW'(g));
    end
  endgenerate

  assign rd_set = rd_tim_all[idx*TIM_W +: TIM_W];
  assign wr_set = wr_tim_all[idx*TIM_W +: TIM_W];
  assign tim    = is_wr ? amc_tim_t'(wr_set) : amc_tim_t'(rd_set);
  assign wide   = wide_all[idx];
  assign mux    = mux_all[idx];
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       is_wr,
  input  logic       mux,
  input  amc_tim_t   tim,
  output amc_state_e st_q,
  output amc_state_e st_n,
  output logic       strobe_last
);
  logic [TF_W-1:0] cnt_q, cnt_n;
  logic            wr_q;
  amc_tim_t        tim_q;
  logic            wr_e;
  amc_tim_t        tim_e;

  assign wr_e  = (st_q == ST_IDLE) ? is_wr : wr_q;
  assign tim_e = (st_q == ST_IDLE) ? tim : tim_q;
  assign strobe_last = (st_q == ST_STROBE) && (cnt_q == '0);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (mux) begin
            st_n  = ST_ADDR;
            cnt_n = '0;
          end else if (tim_e.dly != '0) begin
            st_n  = ST_SETUP;
            cnt_n = tim_e.dly - 1'b1;
          end else begin
            st_n  = ST_STROBE;
            cnt_n = tim_e.wst;
          end
        end
      end
      ST_ADDR: begin
        if (tim_e.dly != '0) begin
          st_n  = ST_SETUP;
          cnt_n = tim_e.dly - 1'b1;
        end else begin
          st_n  = ST_STROBE;
          cnt_n = tim_e.wst;
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          st_n  = ST_STROBE;
          cnt_n = tim_e.wst;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else if (wr_e) begin
          st_n = ST_HOLD;
        end else if (tim_e.turn != '0) begin
          st_n  = ST_TURN;
          cnt_n = tim_e.turn - 1'b1;
        end else begin
          st_n = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (tim_e.turn != '0) begin
          st_n  = ST_TURN;
          cnt_n = tim_e.turn - 1'b1;
        end else begin
          st_n = ST_IDLE;
        end
      end
      ST_TURN: begin
        if (cnt_q == '0) st_n = ST_IDLE;
        else             cnt_n = cnt_q - 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      wr_q  <= 1'b0;
      tim_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      if (start) begin
        wr_q  <= is_wr;
        tim_q <= tim;
      end
    end
  end
endmodule

// File: rtl/amc_top.sv
module amc_top
  import amc_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 28,
  parameter int DW    = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [AW-1:0]                 req_addr,
  input  logic [DW-1:0]                 req_wdata,
  output logic                          busy,
  output logic                          done,
  output logic [DW-1:0]                 rd_data,
  input  logic [NBANK*12-1:0]           cfg_rd_tim,
  input  logic [NBANK*12-1:0]           cfg_wr_tim,
  input  logic [NBANK-1:0]              cfg_wide,
  input  logic [NBANK-1:0]              cfg_mux,
  output logic [NBANK-1:0]              mem_cs_n,
  output logic [AW-$clog2(NBANK)-1:0]   mem_addr,
  output logic                          mem_adv_n,
  output logic                          mem_oe_n,
  output logic                          mem_we_n,
  output logic [DW-1:0]                 mem_dq_out,
  output logic                          mem_dq_oe,
  input  logic [DW-1:0]                 mem_dq_in
);
  localparam int BW  = $clog2(NBANK);
  localparam int MAW = AW - BW;
  localparam int HW  = DW / 2;

  logic [NBANK-1:0] sel_live, sel_q, sel_e;
  amc_tim_t         tim_live;
  logic             wide_live, mux_live, wide_q, wide_e;
  logic             wr_q, wr_e;
  logic [MAW-1:0]   maddr_live, maddr_q, maddr_e;
  logic [DW-1:0]    wdata_live, wdata_q, wdata_e;
  logic             start, strobe_last;
  amc_state_e       st_q, st_n;
  logic             cs_on;

  amc_bank_sel #(.NBANK(NBANK), .AW(AW)) u_sel (
    .addr       (req_addr),
    .is_wr      (req_write),
    .rd_tim_all (cfg_rd_tim),
    .wr_tim_all (cfg_wr_tim),
    .wide_all   (cfg_wide),
    .mux_all    (cfg_mux),
    .sel_oh     (sel_live),
    .tim        (tim_live),
    .wide       (wide_live),
    .mux        (mux_live)
  );

  assign start = req_valid && (st_q == ST_IDLE);

  amc_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .is_wr       (req_write),
    .mux         (mux_live),
    .tim         (tim_live),
    .st_q        (st_q),
    .st_n        (st_n),
    .strobe_last (strobe_last)
  );

  assign maddr_live = wide_live ? {1'b0, req_addr[MAW-1:1]} : req_addr[MAW-1:0];
  assign wdata_live = wide_live ? req_wdata : {{(DW-HW){1'b0}}, req_wdata[HW-1:0]};

  assign sel_e   = start ? sel_live   : sel_q;
  assign wr_e    = start ? req_write  : wr_q;
  assign wide_e  = start ? wide_live  : wide_q;
  assign maddr_e = start ? maddr_live : maddr_q;
  assign wdata_e = start ? wdata_live : wdata_q;
  assign cs_on   = (st_n != ST_IDLE) && (st_n != ST_TURN);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      wr_q       <= 1'b0;
      wide_q     <= 1'b0;
      maddr_q    <= '0;
      wdata_q    <= '0;
      mem_cs_n   <= '1;
      mem_addr   <= '0;
      mem_adv_n  <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      rd_data    <= '0;
    end else begin
      if (start) begin
        sel_q   <= sel_live;
        wr_q    <= req_write;
        wide_q  <= wide_live;
        maddr_q <= maddr_live;
        wdata_q <= wdata_live;
      end
      mem_cs_n  <= cs_on ? ~sel_e : '1;
      if (st_n != ST_IDLE) mem_addr <= maddr_e;
      mem_adv_n <= !(st_n == ST_ADDR);
      mem_oe_n  <= !((st_n == ST_STROBE) && !wr_e);
      mem_we_n  <= !((st_n == ST_STROBE) && wr_e);
      mem_dq_oe <= (st_n == ST_ADDR) ||
                   (wr_e && ((st_n == ST_STROBE) || (st_n == ST_HOLD)));
      mem_dq_out <= (st_n == ST_ADDR) ? maddr_e[DW-1:0] : wdata_e;
      busy      <= (st_n != ST_IDLE);
      done      <= (st_q != ST_IDLE) && (st_n == ST_IDLE);
      if (strobe_last && !wr_q)
        rd_data <= wide_e ? mem_dq_in : {{(DW-HW){1'b0}}, mem_dq_in[HW-1:0]};
    end
  end
endmodule

// File: rtl/amc_chk.sv
module amc_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NBANK-1:0] cs_n,
  input logic             oe_n,
  input logic             we_n,
  input logic             adv_n,
  input logic             dq_oe,
  input logic             done,
  input logic             busy
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1); // R1
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!oe_n || !we_n) |-> (cs_n != '1)); // R4
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n)); // R6
  AST_WE_BEFORE_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (dq_oe && (cs_n != '1))); // R6
  AST_ADDR_PHASE: assert property (@(posedge clk) disable iff (rst)
    !adv_n |-> (dq_oe && oe_n && we_n)); // R3
  AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !dq_oe); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && (cs_n == '1))); // R8
endmodule

bind amc_top amc_chk #(.NBANK(NBANK)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (mem_cs_n),
  .oe_n  (mem_oe_n),
  .we_n  (mem_we_n),
  .adv_n (mem_adv_n),
  .dq_oe (mem_dq_oe),
  .done  (done),
  .busy  (busy)
);

// File: tb/sim_amc_top.sv
module sim_amc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [27:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done;
  logic [15:0] rd_data;
  logic [47:0] cfg_rd_tim, cfg_wr_tim;
  logic [3:0]  cfg_wide, cfg_mux;
  logic [3:0]  mem_cs_n;
  logic [25:0] mem_addr;
  logic        mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_dq_in = mem_addr[15:0] ^ 16'hA5C3;

  amc_top u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .cfg_rd_tim(cfg_rd_tim), .cfg_wr_tim(cfg_wr_tim),
    .cfg_wide(cfg_wide), .cfg_mux(cfg_mux), .mem_cs_n(mem_cs_n),
    .mem_addr(mem_addr), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // per-bank settings: wait, strobe delay, turnaround
  int rw[4] = '{2, 0, 15, 0};
  int rd[4] = '{1, 0, 15, 0};
  int rt[4] = '{1, 3, 15, 0};
  int ww[4] = '{0, 3, 1, 15};
  int wd[4] = '{0, 2, 0, 15};
  int wt[4] = '{0, 2, 0, 15};
  logic [3:0] wide_cfg = 4'b0101;
  logic [3:0] mux_cfg  = 4'b0110;

  typedef struct {
    logic        wr;
    logic [3:0]  cs;
    int          cyc, adv, pre, strb, hold, turn;
    logic [25:0] addr;
    logic [15:0] data;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [27:0] a, input logic [15:0] wdv);
    exp_t e;
    int b, w, d, t, m;
    b = int'(a[27:26]);
    m = mux_cfg[b] ? 1 : 0;
    w = wr ? ww[b] : rw[b];
    d = wr ? wd[b] : rd[b];
    t = wr ? wt[b] : rt[b];
    e.wr   = wr;
    e.cs   = ~(4'b0001 << b);
    e.adv  = m;
    e.pre  = m + d;
    e.strb = w + 1;
    e.hold = wr ? 1 : 0;
    e.cyc  = m + d + w + 1 + e.hold;
    e.turn = t;
    e.addr = wide_cfg[b] ? {1'b0, a[25:1]} : a[25:0];
    if (wr) e.data = wide_cfg[b] ? wdv : {8'h00, wdv[7:0]};
    else    e.data = wide_cfg[b] ? (e.addr[15:0] ^ 16'hA5C3)
                                 : {8'h00, e.addr[7:0] ^ 8'hC3};
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = wdv;
    while (busy) @(negedge clk);
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", {31'd0, busy}, 32'd1);
  endtask

  // monitor
  logic [3:0]  o_cs;
  int          o_cyc = 0, o_adv = 0, o_pre = 0, o_strb = 0, o_hold = 0, o_turn = 0;
  logic        o_csbad = 1'b0;
  logic [25:0] o_addr;
  logic [15:0] o_wd;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_cs_n != 4'hF) begin
        if (o_cyc == 0) o_cs = mem_cs_n;
        else if (mem_cs_n != o_cs) o_csbad = 1'b1;
        o_cyc++;
        if (!mem_adv_n) begin
          o_adv++;
          chk(mem_dq_oe && (mem_dq_out == mem_addr[15:0]), "R3 address phase",
              {16'd0, mem_dq_out}, {16'd0, mem_addr[15:0]});
        end
        if (!mem_oe_n || !mem_we_n) begin
          if (o_strb == 0) o_addr = mem_addr;
          o_strb++;
          if (!mem_we_n) o_wd = mem_dq_out;
        end else if (o_strb == 0) begin
          o_pre++;
        end else begin
          o_hold++;
          chk(mem_dq_oe && (mem_dq_out == o_wd), "R6 write hold",
              {15'd0, mem_dq_oe, mem_dq_out}, {15'd0, 1'b1, o_wd});
        end
      end else if (busy) begin
        o_turn++;
      end
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R10 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(!busy, "R10 busy low with done", {31'd0, busy}, 32'd0);
          chk(!o_csbad && o_cs == e.cs, "R1 chip select", {27'd0, o_csbad, o_cs}, {28'd0, e.cs});
          chk(o_cyc == e.cyc, "R1 select length", o_cyc, e.cyc);
          chk(o_adv == e.adv, "R3 address phase count", o_adv, e.adv);
          chk(o_pre == e.pre, "R4 strobe delay", o_pre, e.pre);
          chk(o_strb == e.strb, "R5 wait states", o_strb, e.strb);
          chk(o_hold == e.hold, "R6 hold cycle", o_hold, e.hold);
          chk(o_turn == e.turn, "R8 turnaround", o_turn, e.turn);
          chk(o_addr == e.addr, "R2 address", {6'd0, o_addr}, {6'd0, e.addr});
          if (e.wr) chk(o_wd == e.data, "R6 write data", {16'd0, o_wd}, {16'd0, e.data});
          else      chk(rd_data == e.data, "R7 read data", {16'd0, rd_data}, {16'd0, e.data});
        end
        o_cyc = 0; o_adv = 0; o_pre = 0; o_strb = 0; o_hold = 0; o_turn = 0;
        o_csbad = 1'b0;
      end
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) begin
      cfg_rd_tim[b*12 +: 12] = {4'(rt[b]), 4'(rd[b]), 4'(rw[b])};
      cfg_wr_tim[b*12 +: 12] = {4'(wt[b]), 4'(wd[b]), 4'(ww[b])};
    end
    cfg_wide = wide_cfg;
    cfg_mux  = mux_cfg;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && mem_adv_n, "R11 strobes idle",
        {28'd0, mem_cs_n}, 32'hF);
    chk(!mem_dq_oe && !busy && !done, "R11 flags low",
        {29'd0, mem_dq_oe, busy, done}, 32'd0);

    fork
      begin
        // R9: reads and writes on every bank with differing sets
        issue(1'b0, 28'h0001234, 16'h0);
        issue(1'b1, 28'h0002468, 16'hBEEF);
        issue(1'b0, 28'h4005679, 16'h0);
        issue(1'b1, 28'h40000A5, 16'h1234);
        issue(1'b0, 28'h8003456, 16'h0);
        issue(1'b1, 28'h800FFFE, 16'hCAFE);
        issue(1'b0, 28'hC0000F1, 16'h0);
        issue(1'b1, 28'hC001357, 16'h5A7E);
        // back to back, next request waiting while busy (R10)
        issue(1'b1, 28'h0000010, 16'h0F0F);
        issue(1'b0, 28'h0000011, 16'h0);
        issue(1'b0, 28'h4000003, 16'h0);
        issue(1'b1, 28'hC0000FF, 16'h00AA);
        issue(1'b0, 28'h83FFFFF, 16'h0);
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(!busy && mem_cs_n == 4'hF, "R10 idle after drain",
            {27'd0, busy, mem_cs_n}, 32'hF);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule